// File: doc/BRIEF.md
# Read Data Completion Reassembly Buffer

This block sits on the return path of a read-issuing engine. Each read request that goes out first takes a slot from the buffer. The requester records its own transaction ID and the expected burst length in that slot, and it tags the outgoing read with the slot number. Read-data beats then come back on an AXI-style R input that carries the slot tag. Beats of different reads may be interleaved freely. The buffer writes each beat into the storage of its slot.

A slot is closed when the beat marked last is written. Its index then joins a queue of finished slots. The output side drains that queue in the order the slots finished, not in the order they were requested. It sends each burst as a stream with valid/ready handshaking and a last marker, and it frees the slot when the final beat has been accepted.

Beats that cannot be placed are dropped and raise a sticky error flag. This covers a beat for a slot that is not filling, a beat past the allocated length, and, when interleave support is disabled by parameter, a beat that breaks into another slot's open burst. The parameter `INTERLEAVE` defaults to 0. With it set to 0, beats of one burst must arrive back to back.

Top module: `rrb_reassembly_buffer`

## Requirements
- R1: After reset every slot is free: `alloc_ready` is 1, `alloc_slot` is 0, `o_valid` is 0 and `err_unalloc` is 0.
- R2: `alloc_slot` always shows the lowest-numbered free slot. A cycle with `alloc_valid` and `alloc_ready` both high claims that slot. When no slot is free, `alloc_ready` is 0 and `alloc_valid` has no effect.
- R3: Each beat accepted for a filling slot is stored. The slot's burst is later emitted with the same `r_data` and `r_resp` values, in the order the beats arrived. Beats for different slots may interleave when `INTERLEAVE` is 1.
- R4: An accepted beat with `r_last` high completes its slot. `o_valid` reflects the completion in the cycle after that beat's clock edge. Completed bursts leave strictly in completion order, and each beat carries the `alloc_id` recorded at allocation on `o_id`.
- R5: `o_last` is high exactly on the final stored beat of a burst. While `o_valid` is high and `o_ready` is low, the output fields hold their values.
- R6: The handshake of a burst's final beat returns its slot to the free pool. From the next cycle the slot can be allocated again.
- R7: A beat whose slot is free or already complete is dropped, and `err_unalloc` goes high and stays high until reset.
- R8: A beat arriving after a slot already holds its allocated number of beats is dropped, including its last marker, and it sets `err_unalloc`.
- R9: With `INTERLEAVE` = 0, a beat for another slot while a burst is open is dropped and sets `err_unalloc`. A burst is open once a non-last beat has been accepted and until its last beat is accepted.
- R10: `alloc_len` holds the beat count minus one. A beat with `r_last` high that arrives before the allocated count still completes the slot, and the burst then carries only the beats received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to claim a slot |
| alloc_ready | output | 1 | At least one slot is free |
| alloc_id | input | ID_W | Transaction ID kept for the output |
| alloc_len | input | $clog2(MAX_BEATS) | Burst beat count minus one |
| alloc_slot | output | $clog2(NUM_SLOTS) | Slot granted on this cycle's handshake |
| r_valid | input | 1 | Read beat present |
| r_slot | input | $clog2(NUM_SLOTS) | Slot tag of the beat |
| r_data | input | DATA_W | Read data |
| r_resp | input | 2 | Read response code |
| r_last | input | 1 | Final beat of the burst |
| o_valid | output | 1 | Output beat available |
| o_ready | input | 1 | Downstream accepts the beat |
| o_id | output | ID_W | Transaction ID of the burst |
| o_data | output | DATA_W | Beat data |
| o_resp | output | 2 | Beat response code |
| o_last | output | 1 | Final beat of the burst |
| err_unalloc | output | 1 | Sticky dropped-beat flag |

## Verification
A corrupted slot state shows up at the ports at once: `alloc_slot` or `alloc_ready` disagrees with the free set in the very next cycle. A lost or misordered completion shows as a wrong `o_id`, or as `o_valid` rising one cycle off, at the head of the next burst. A miscounted beat index surfaces when that burst drains, either as wrong data or as `o_last` on the wrong beat. An acceptance gate that is too loose or too strict flips `err_unalloc` on the cycle after the offending beat. The bench runs a reference model beside the design on every clock, so each of these faults is caught at the first cycle it becomes visible.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    localparam int DEF_SLOTS  = 16;
    localparam int DEF_BEATS  = 8;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_ID_W   = 4;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_FILL = 2'd1,
        SLOT_DONE = 2'd2
    } slot_state_e;

    typedef logic [1:0] rresp_t;

endpackage

// File: rtl/rrb_slot_table.sv
module rrb_slot_table
    import rrb_pkg::*;
#(
    parameter int NUM_SLOTS  = DEF_SLOTS,
    parameter int MAX_BEATS  = DEF_BEATS,
    parameter int ID_W       = DEF_ID_W,
    parameter bit INTERLEAVE = 1'b0,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int BEAT_W    = $clog2(MAX_BEATS),
    localparam int CNT_W     = $clog2(MAX_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic [BEAT_W-1:0] alloc_len,
    input  logic              r_valid,
    input  logic [SLOT_W-1:0] r_slot,
    input  logic              r_last,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [BEAT_W-1:0] wr_beat,
    output logic              done_push,
    output logic [SLOT_W-1:0] done_slot,
    input  logic              rel_valid,
    input  logic [SLOT_W-1:0] rel_slot,
    input  logic [SLOT_W-1:0] q_slot,
    output logic [CNT_W-1:0]  q_cnt,
    output logic [ID_W-1:0]   q_id,
    output logic              bad_beat
);

    slot_state_e       st    [NUM_SLOTS];
    logic [CNT_W-1:0]  cnt   [NUM_SLOTS];
    logic [BEAT_W-1:0] lenm1 [NUM_SLOTS];
    logic [ID_W-1:0]   id    [NUM_SLOTS];

    logic [NUM_SLOTS-1:0] free_vec;
    logic                 alloc_fire;
    logic                 slot_filling;
    logic                 in_bound;
    logic                 order_ok;
    logic                 beat_ok;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_free
        assign free_vec[g] = (st[g] == SLOT_FREE);
    end

    // lowest-numbered free slot wins
    always_comb begin
        alloc_slot = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (free_vec[i]) alloc_slot = SLOT_W'(i);
        end
    end

    assign alloc_ready = |free_vec;
    assign alloc_fire  = alloc_valid && alloc_ready;

    assign slot_filling = (st[r_slot] == SLOT_FILL);
    assign in_bound     = (cnt[r_slot] <= CNT_W'(lenm1[r_slot]));

    if (INTERLEAVE) begin : g_ilv
        assign order_ok = 1'b1;
    end else begin : g_contig
        logic              open_q;
        logic [SLOT_W-1:0] open_slot_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q      <= 1'b0;
                open_slot_q <= '0;
            end else if (beat_ok) begin
                open_q      <= !r_last;
                open_slot_q <= r_slot;
            end
        end

        assign order_ok = !open_q || (open_slot_q == r_slot);

        // R9: a non-last beat is followed only by beats of the same slot
        assert_contiguous_R9: assert property (@(posedge clk) disable iff (rst)
            (beat_ok && !r_last) |=> (!beat_ok || (r_slot == $past(r_slot))));
    end

    assign beat_ok   = r_valid && slot_filling && in_bound && order_ok;
    assign bad_beat  = r_valid && !beat_ok;
    assign wr_en     = beat_ok;
    assign wr_slot   = r_slot;
    assign wr_beat   = cnt[r_slot][BEAT_W-1:0];
    assign done_push = beat_ok && r_last;
    assign done_slot = r_slot;
    assign q_cnt     = cnt[q_slot];
    assign q_id      = id[q_slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                st[i]    <= SLOT_FREE;
                cnt[i]   <= '0;
                lenm1[i] <= '0;
                id[i]    <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (alloc_fire && alloc_slot == SLOT_W'(i)) begin
                    st[i]    <= SLOT_FILL;
                    cnt[i]   <= '0;
                    lenm1[i] <= alloc_len;
                    id[i]    <= alloc_id;
                end else if (beat_ok && r_slot == SLOT_W'(i)) begin
                    cnt[i] <= cnt[i] + CNT_W'(1);
                    if (r_last) st[i] <= SLOT_DONE;
                end else if (rel_valid && rel_slot == SLOT_W'(i)) begin
                    st[i] <= SLOT_FREE;
                end
            end
        end
    end

    // R6: only a completed slot is handed back to the free pool
    assert_release_done_R6: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> (st[rel_slot] == SLOT_DONE));

endmodule

// File: rtl/rrb_done_fifo.sv
module rrb_done_fifo #(
    parameter int DEPTH  = 16,
    parameter int W      = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head      = mem[rd_ptr];
    assign not_empty = (count != '0);

    // R4: each slot completes once per allocation, so the queue never overruns
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH) || pop));

    // R5: the output side only drains a queued burst
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> not_empty);

endmodule

// File: rtl/rrb_beat_store.sv
module rrb_beat_store #(
    parameter int NUM_SLOTS = 16,
    parameter int MAX_BEATS = 8,
    parameter int W         = 34,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int BEAT_W   = $clog2(MAX_BEATS),
    localparam int ENTRIES  = NUM_SLOTS * MAX_BEATS,
    localparam int ADDR_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic [W-1:0]      wr_word,
    input  logic [SLOT_W-1:0] rd_slot,
    input  logic [BEAT_W-1:0] rd_beat,
    output logic [W-1:0]      rd_word
);

    logic [W-1:0]      mem [ENTRIES];
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;

    assign wr_addr = ADDR_W'(wr_slot) * ADDR_W'(MAX_BEATS) + ADDR_W'(wr_beat);
    assign rd_addr = ADDR_W'(rd_slot) * ADDR_W'(MAX_BEATS) + ADDR_W'(rd_beat);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_word;
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/rrb_reassembly_buffer.sv
module rrb_reassembly_buffer
    import rrb_pkg::*;
#(
    parameter int NUM_SLOTS  = DEF_SLOTS,
    parameter int MAX_BEATS  = DEF_BEATS,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int ID_W       = DEF_ID_W,
    parameter bit INTERLEAVE = 1'b0,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int BEAT_W    = $clog2(MAX_BEATS),
    localparam int CNT_W     = $clog2(MAX_BEATS + 1),
    localparam int WORD_W    = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic [BEAT_W-1:0] alloc_len,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              r_valid,
    input  logic [SLOT_W-1:0] r_slot,
    input  logic [DATA_W-1:0] r_data,
    input  rresp_t            r_resp,
    input  logic              r_last,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [ID_W-1:0]   o_id,
    output logic [DATA_W-1:0] o_data,
    output rresp_t            o_resp,
    output logic              o_last,
    output logic              err_unalloc
);

    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic [BEAT_W-1:0] wr_beat;
    logic              done_push;
    logic [SLOT_W-1:0] done_slot;
    logic              rel_valid;
    logic [SLOT_W-1:0] head_slot;
    logic [CNT_W-1:0]  head_cnt;
    logic              bad_beat;
    logic              q_nempty;
    logic [CNT_W-1:0]  rd_ptr;
    logic [WORD_W-1:0] rd_word;
    logic              o_fire;

    rrb_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .MAX_BEATS (MAX_BEATS),
        .ID_W      (ID_W),
        .INTERLEAVE(INTERLEAVE)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .alloc_valid(alloc_valid),
        .alloc_ready(alloc_ready),
        .alloc_slot (alloc_slot),
        .alloc_id   (alloc_id),
        .alloc_len  (alloc_len),
        .r_valid    (r_valid),
        .r_slot     (r_slot),
        .r_last     (r_last),
        .wr_en      (wr_en),
        .wr_slot    (wr_slot),
        .wr_beat    (wr_beat),
        .done_push  (done_push),
        .done_slot  (done_slot),
        .rel_valid  (rel_valid),
        .rel_slot   (head_slot),
        .q_slot     (head_slot),
        .q_cnt      (head_cnt),
        .q_id       (o_id),
        .bad_beat   (bad_beat)
    );

    rrb_done_fifo #(
        .DEPTH(NUM_SLOTS),
        .W    (SLOT_W)
    ) u_done_q (
        .clk      (clk),
        .rst      (rst),
        .push     (done_push),
        .push_data(done_slot),
        .pop      (rel_valid),
        .head     (head_slot),
        .not_empty(q_nempty)
    );

    rrb_beat_store #(
        .NUM_SLOTS(NUM_SLOTS),
        .MAX_BEATS(MAX_BEATS),
        .W        (WORD_W)
    ) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_slot(wr_slot),
        .wr_beat(wr_beat),
        .wr_word({r_resp, r_data}),
        .rd_slot(head_slot),
        .rd_beat(rd_ptr[BEAT_W-1:0]),
        .rd_word(rd_word)
    );

    assign o_valid   = q_nempty;
    assign o_last    = (rd_ptr == head_cnt - CNT_W'(1));
    assign o_data    = rd_word[DATA_W-1:0];
    assign o_resp    = rresp_t'(rd_word[WORD_W-1:DATA_W]);
    assign o_fire    = o_valid && o_ready;
    assign rel_valid = o_fire && o_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
        end else if (o_fire) begin
            rd_ptr <= o_last ? '0 : rd_ptr + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_unalloc <= 1'b0;
        end else if (bad_beat) begin
            err_unalloc <= 1'b1;
        end
    end

    // R5: a stalled output beat keeps every field
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_id)
                                   && $stable(o_resp) && $stable(o_last)));

    // R7: the dropped-beat flag never clears on its own
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err_unalloc |=> err_unalloc);

    // R6: after a final handshake some slot is available
    assert_free_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_ready && o_last) |=> alloc_ready);

endmodule

// File: tb/tb_rrb_reassembly_buffer.sv
module tb_rrb_reassembly_buffer;

    localparam int NS = 16;
    localparam int MB = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 0, r_valid = 0, r_last = 0, o_ready = 0;
    logic [3:0]  alloc_id = 0, r_slot = 0, alloc_slot, o_id;
    logic [2:0]  alloc_len = 0;
    logic [31:0] r_data = 0, o_data;
    logic [1:0]  r_resp = 0, o_resp;
    logic        alloc_ready, o_valid, o_last, err;

    logic        n_alloc_valid = 0, n_r_valid = 0, n_r_last = 0;
    logic [3:0]  n_r_slot = 0, n_alloc_slot, n_o_id;
    logic [31:0] n_r_data = 0, n_o_data;
    logic [1:0]  n_o_resp;
    logic        n_alloc_ready, n_o_valid, n_o_last, n_err;

    int tests = 0, fails = 0, cyc = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    rrb_reassembly_buffer #(.NUM_SLOTS(NS), .MAX_BEATS(MB), .DATA_W(32), .ID_W(4), .INTERLEAVE(1'b1)) dut (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .alloc_id(alloc_id), .alloc_len(alloc_len), .alloc_slot(alloc_slot),
        .r_valid(r_valid), .r_slot(r_slot), .r_data(r_data), .r_resp(r_resp), .r_last(r_last),
        .o_valid(o_valid), .o_ready(o_ready), .o_id(o_id), .o_data(o_data), .o_resp(o_resp),
        .o_last(o_last), .err_unalloc(err));

    rrb_reassembly_buffer #(.NUM_SLOTS(NS), .MAX_BEATS(MB), .DATA_W(32), .ID_W(4), .INTERLEAVE(1'b0)) dut_ni (
        .clk(clk), .rst(rst), .alloc_valid(n_alloc_valid), .alloc_ready(n_alloc_ready),
        .alloc_id(4'd9), .alloc_len(3'd1), .alloc_slot(n_alloc_slot),
        .r_valid(n_r_valid), .r_slot(n_r_slot), .r_data(n_r_data), .r_resp(2'd0), .r_last(n_r_last),
        .o_valid(n_o_valid), .o_ready(1'b0), .o_id(n_o_id), .o_data(n_o_data), .o_resp(n_o_resp),
        .o_last(n_o_last), .err_unalloc(n_err));

    // behavioural reference: 0 free, 1 filling, 2 complete
    int          m_st  [NS];
    int          m_len [NS];
    int          m_id  [NS];
    logic [33:0] m_beats [NS][$];
    int          m_done [$];
    int          m_rd;
    bit          m_err;
    int          cand [NS];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        int  a, h;
        bit  ov, fire, lst, okb;
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
        if (rst) begin
            for (int i = 0; i < NS; i++) begin
                m_st[i] = 0; m_len[i] = 0; m_id[i] = 0; m_beats[i].delete();
            end
            m_done.delete(); m_rd = 0; m_err = 0;
        end else begin
            a = -1;
            for (int i = NS - 1; i >= 0; i--) if (m_st[i] == 0) a = i;
            ov   = m_done.size() > 0;
            h    = ov ? m_done[0] : 0;
            fire = ov && o_ready;
            lst  = ov && (m_rd == m_beats[h].size() - 1);
            okb  = r_valid && m_st[r_slot] == 1 && m_beats[r_slot].size() < m_len[r_slot];
            if (r_valid && !okb) m_err = 1;
            if (fire) begin
                if (lst) begin
                    void'(m_done.pop_front()); m_st[h] = 0; m_rd = 0;
                end else m_rd++;
            end
            if (okb) begin
                m_beats[r_slot].push_back({r_resp, r_data});
                if (r_last) begin m_st[r_slot] = 2; m_done.push_back(int'(r_slot)); end
            end
            if (alloc_valid && a >= 0) begin
                m_st[a] = 1; m_beats[a].delete();
                m_len[a] = int'(alloc_len) + 1; m_id[a] = int'(alloc_id);
            end
        end
    end

    always @(negedge clk) begin
        int h, es;
        bit er;
        logic [33:0] w;
        if (cmp_on && !rst) begin
            er = 0; es = 0;
            for (int i = NS - 1; i >= 0; i--) if (m_st[i] == 0) begin er = 1; es = i; end
            chk("R2 alloc_ready", 64'(alloc_ready), 64'(er));
            if (er) chk("R2 alloc_slot", 64'(alloc_slot), 64'(es));
            chk("R4 o_valid", 64'(o_valid), 64'(m_done.size() > 0));
            if (m_done.size() > 0 && o_valid) begin
                h = m_done[0];
                w = m_beats[h][m_rd];
                chk("R4 o_id", 64'(o_id), 64'(m_id[h]));
                chk("R3 o_data", 64'(o_data), 64'(w[31:0]));
                chk("R3 o_resp", 64'(o_resp), 64'(w[33:32]));
                chk("R5 o_last", 64'(o_last), 64'(m_rd == m_beats[h].size() - 1));
            end
            chk("R7 err_unalloc", 64'(err), 64'(m_err));
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [3:0] id, input logic [2:0] lm1, output logic [3:0] s);
        alloc_valid = 1; alloc_id = id; alloc_len = lm1;
        s = alloc_slot;
        @(negedge clk);
        alloc_valid = 0;
    endtask

    task automatic beat(input logic [3:0] s, input logic [31:0] d, input logic l);
        r_valid = 1; r_slot = s; r_data = d; r_resp = d[1:0]; r_last = l;
        @(negedge clk);
        r_valid = 0; r_last = 0;
    endtask

    initial begin
        logic [3:0]  s0, s1, s2, sx;
        logic [31:0] held;
        logic [3:0]  exp_id [6];
        logic [31:0] exp_d  [6];

        do_reset();
        cmp_on = 1;
        // R1 reset state
        chk("R1 alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1 alloc_slot", 64'(alloc_slot), 64'd0);
        chk("R1 o_valid", 64'(o_valid), 64'd0);
        chk("R1 err", 64'(err), 64'd0);

        // interleaved bursts finishing out of request order
        o_ready = 0;
        do_alloc(4'd5, 3'd1, s0);
        do_alloc(4'd6, 3'd2, s1);
        do_alloc(4'd7, 3'd0, s2);
        chk("R2 first slot", 64'(s0), 64'd0);
        chk("R2 second slot", 64'(s1), 64'd1);
        chk("R2 third slot", 64'(s2), 64'd2);
        beat(4'd1, 32'h1110, 0);
        beat(4'd0, 32'h0A00, 0);
        beat(4'd2, 32'h2C02, 1);
        chk("R4 valid one cycle after last", 64'(o_valid), 64'd1);
        chk("R4 first out id", 64'(o_id), 64'd7);
        beat(4'd1, 32'h1111, 0);
        beat(4'd0, 32'h0A01, 1);
        beat(4'd1, 32'h1112, 1);
        held = o_data;
        @(negedge clk);
        chk("R5 held while stalled", 64'(o_data), 64'(held));
        exp_id = '{4'd7, 4'd5, 4'd5, 4'd6, 4'd6, 4'd6};
        exp_d  = '{32'h2C02, 32'h0A00, 32'h0A01, 32'h1110, 32'h1111, 32'h1112};
        o_ready = 1;
        for (int k = 0; k < 6; k++) begin
            chk("R4 order id", 64'(o_id), 64'(exp_id[k]));
            chk("R3 order data", 64'(o_data), 64'(exp_d[k]));
            @(negedge clk);
        end
        chk("R4 drained", 64'(o_valid), 64'd0);

        // exhaust slots, then free one
        o_ready = 0;
        do_reset();
        for (int i = 0; i < NS; i++) do_alloc(4'(i), 3'd0, sx);
        chk("R2 full stalls", 64'(alloc_ready), 64'd0);
        alloc_valid = 1; @(negedge clk); alloc_valid = 0;
        chk("R2 still stalled", 64'(alloc_ready), 64'd0);
        beat(4'd9, 32'h9999, 1);
        o_ready = 1; @(negedge clk); o_ready = 0;
        chk("R6 slot returned", 64'(alloc_ready), 64'd1);
        chk("R6 returned index", 64'(alloc_slot), 64'd9);

        // beats for free and complete slots
        do_reset();
        beat(4'd3, 32'h3333, 1);
        chk("R7 free slot beat flags", 64'(err), 64'd1);
        chk("R7 free slot beat dropped", 64'(o_valid), 64'd0);
        do_alloc(4'd1, 3'd0, sx);
        beat(sx, 32'h4444, 1);
        beat(sx, 32'h5555, 1);
        chk("R7 complete slot keeps one beat", 64'(o_last), 64'd1);
        chk("R7 complete slot data", 64'(o_data), 64'h4444);

        // overrun of allocated length
        do_reset();
        do_alloc(4'd2, 3'd1, sx);
        beat(sx, 32'hD0, 0);
        beat(sx, 32'hD1, 0);
        chk("R8 no error in bound", 64'(err), 64'd0);
        beat(sx, 32'hD2, 1);
        chk("R8 overrun flags", 64'(err), 64'd1);
        chk("R8 overrun last dropped", 64'(o_valid), 64'd0);

        // early last
        do_reset();
        do_alloc(4'd3, 3'd3, sx);
        beat(sx, 32'hE0, 0);
        beat(sx, 32'hE1, 1);
        chk("R10 early last completes", 64'(o_valid), 64'd1);
        chk("R10 first beat not last", 64'(o_last), 64'd0);
        o_ready = 1; @(negedge clk); o_ready = 0;
        chk("R10 second beat last", 64'(o_last), 64'd1);
        chk("R10 second beat data", 64'(o_data), 64'hE1);
        chk("R10 no error", 64'(err), 64'd0);

        // mixed traffic against the model
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            int nc;
            alloc_valid = ($urandom % 3) == 0;
            alloc_id    = 4'($urandom);
            alloc_len   = 3'($urandom);
            o_ready     = ($urandom % 4) != 0;
            r_valid = 0; r_last = 0;
            if ($urandom % 40 == 0) begin
                r_valid = 1; r_slot = 4'($urandom); r_data = $urandom;
                r_resp = 2'($urandom); r_last = 1'($urandom);
            end else begin
                nc = 0;
                for (int i = 0; i < NS; i++)
                    if (m_st[i] == 1 && m_beats[i].size() < m_len[i]) begin cand[nc] = i; nc++; end
                if (nc > 0 && ($urandom % 4) != 0) begin
                    int s;
                    s = cand[$urandom % nc];
                    r_valid = 1; r_slot = 4'(s); r_data = $urandom; r_resp = 2'($urandom);
                    r_last = (m_beats[s].size() == m_len[s] - 1) || ($urandom % 10 == 0);
                end
            end
            @(negedge clk);
        end
        alloc_valid = 0; r_valid = 0; r_last = 0; o_ready = 1;
        repeat (200) @(negedge clk);

        // contiguous-only variant
        cmp_on = 0;
        do_reset();
        n_alloc_valid = 1; @(negedge clk); @(negedge clk); n_alloc_valid = 0;
        n_r_valid = 1; n_r_slot = 4'd0; n_r_data = 32'hF0; n_r_last = 0; @(negedge clk);
        n_r_slot = 4'd1; n_r_data = 32'hF1; n_r_last = 1; @(negedge clk);
        chk("R9 interleaved beat flags", 64'(n_err), 64'd1);
        chk("R9 interleaved beat dropped", 64'(n_o_valid), 64'd0);
        n_r_slot = 4'd0; n_r_data = 32'hF2; n_r_last = 1; @(negedge clk);
        n_r_valid = 0; n_r_last = 0;
        chk("R9 open burst completes", 64'(n_o_valid), 64'd1);
        chk("R9 burst data", 64'(n_o_data), 64'hF0);
        chk("R9 burst id", 64'(n_o_id), 64'd9);

        finish_run();
    end

endmodule